// File: doc/BRIEF.md
# Chip-Select-Gated Registered Command Buffer

This block sits on the command/address path of a memory module. It registers a wide data field together with small groups of chip-select, clock-enable and termination-control bits on every rising clock edge, and drives the registered copies out to the memory devices.

A mode input decides when the data field may update. With the mode low, the data field loads on every edge. With the mode high, it loads only on edges where at least one chip select is active (low). On all other edges the data field keeps its previous value. The chip-select, clock-enable and termination bits are never held back by this gating.

A parity bit for each command arrives one cycle after the command's data. It is checked as even parity against the registered data, and the result appears one cycle after the data output as an active-low error flag. Only cycles that actually loaded data are checked. Reset is asserted asynchronously and active low. Its release is synchronised to the clock by a short flop chain inside the block.

Top module: `cmd_regbuf`

## Requirements
- R1: With `gate_en` = 0, `q_out` takes the value of `d_in` at every rising edge, whatever the value of `cs_n_in`.
- R2: With `gate_en` = 1, `q_out` takes the value of `d_in` at each rising edge where `cs_n_in` has at least one bit equal to 0.
- R3: With `gate_en` = 1 and every `cs_n_in` bit equal to 1, `d_in` is ignored at that edge and `q_out` keeps its previous value.
- R4: `cs_n_out`, `cke_out` and `odt_out` take the values of `cs_n_in`, `cke_in` and `odt_in` at every rising edge, in both modes and for any chip-select value.
- R5: Suppose `q_out` was loaded at edge k. At edge k+1, `err_n` becomes 0 if the XOR of all `q_out` bits and `par_in` is 1 (a mismatch under even parity), and becomes 1 otherwise. It holds that value until edge k+2.
- R6: If the data register was not loaded at edge k, `err_n` is 1 after edge k+1, whatever the value of `par_in`.
- R7: While `rst_n` is 0, the outputs are forced at once, without a clock edge, to these values: `q_out`, `cs_n_out`, `cke_out` and `odt_out` all 0, and `err_n` = 1.
- R8: After reset, the first edge that loads data leaves `err_n` = 1. The error flag can first go to 0 one edge later.
- R9: Reset release is synchronous. Take `rst_n` rising between edges. The outputs keep their reset values through the next two rising edges, and the first register load happens on the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en | input | 1 | 1 = data field loads only when a chip select is low |
| d_in | input | DATA_W | Command/address data field |
| cs_n_in | input | CS_W | Active-low chip selects |
| cke_in | input | CKE_W | Clock-enable bits |
| odt_in | input | ODT_W | Termination-control bits |
| par_in | input | 1 | Even-parity bit for the data captured one cycle earlier |
| q_out | output | DATA_W | Registered data field |
| cs_n_out | output | CS_W | Registered chip selects |
| cke_out | output | CKE_W | Registered clock enables |
| odt_out | output | ODT_W | Registered termination controls |
| err_n | output | 1 | Active-low parity error flag |

## Verification
The bench builds the block with its default parameters: a 28-bit data field and two bits in each sideband group. With two chip selects, the bench can drive all four select combinations in gated mode and check the hold case where both are high. The parity checks run over the full 28-bit field, with both matching and deliberately flipped parity bits. The reset-release chain has its default depth of two, which gives the exact edge at which the first load happens.

// File: rtl/cmd_regbuf_pkg.sv
package cmd_regbuf_pkg;

  // Why the data register does or does not load at a given edge.
  typedef enum logic [1:0] {
    LOAD_FREE     = 2'd0,  // mode low: load on every edge
    LOAD_SELECTED = 2'd1,  // mode high and a chip select active
    LOAD_BLOCKED  = 2'd2   // mode high and no chip select active
  } load_kind_e;

  // Number of sideband groups (chip select, clock enable, termination).
  localparam int unsigned SIDE_GROUPS = 3;

endpackage

// File: rtl/cmd_regbuf_rst_sync.sv
module cmd_regbuf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_r;
  logic [STAGES-1:0] chain_nxt;

  // Shift ones in from the bottom once reset is released.
  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_nxt = 1'b1;
    end else begin : g_multi
      always_comb chain_nxt = {chain_r[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_r <= '0;
    else        chain_r <= chain_nxt;
  end

  assign rst_n_sync = chain_r[STAGES-1];

endmodule

// File: rtl/cmd_regbuf_gate.sv
module cmd_regbuf_gate
  import cmd_regbuf_pkg::*;
#(
  parameter int unsigned CS_W = 2
) (
  input  logic            gate_en,
  input  logic [CS_W-1:0] cs_n,
  output load_kind_e      kind
);

  logic any_sel;

  always_comb begin
    any_sel = ~(&cs_n);
    if (!gate_en)    kind = LOAD_FREE;
    else if (any_sel) kind = LOAD_SELECTED;
    else              kind = LOAD_BLOCKED;
  end

endmodule

// File: rtl/cmd_regbuf_pipe.sv
module cmd_regbuf_pipe #(
  parameter int unsigned DATA_W = 28,
  parameter int unsigned SIDE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d_in,
  input  logic [SIDE_W-1:0] side_in,
  output logic [DATA_W-1:0] q_out,
  output logic [SIDE_W-1:0] side_out,
  output logic              load_q
);

  logic [DATA_W-1:0] q_r, q_nxt;
  logic [SIDE_W-1:0] side_r;
  logic              load_r;

  // Next state: the data field has an explicit clock enable.
  always_comb begin
    q_nxt = q_r;
    if (load) q_nxt = d_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r    <= '0;
      side_r <= '0;
      load_r <= 1'b0;
    end else begin
      q_r    <= q_nxt;
      side_r <= side_in;
      load_r <= load;
    end
  end

  assign q_out    = q_r;
  assign side_out = side_r;
  assign load_q   = load_r;

  // R1 / R2: a loading edge presents the sampled data.
  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q_out == $past(d_in)));

  // R3: a blocked edge leaves the data field unchanged.
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q_out));

  // R4: sideband bits follow their inputs on every edge.
  assert_side_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (side_out == $past(side_in)));

endmodule

// File: rtl/cmd_regbuf_parity.sv
module cmd_regbuf_parity #(
  parameter int unsigned DATA_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_q,
  input  logic [DATA_W-1:0] q,
  input  logic              par_in,
  output logic              err_n
);

  logic mismatch;
  logic err_n_r, err_n_nxt;

  always_comb begin
    mismatch  = (^q) ^ par_in;
    err_n_nxt = 1'b1;
    if (load_q) err_n_nxt = ~mismatch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_n_r <= 1'b1;
    else        err_n_r <= err_n_nxt;
  end

  assign err_n = err_n_r;

  // R5: a checked cycle reports the parity outcome one edge later.
  assert_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |=> (err_n == !$past((^q) ^ par_in)));

  // R6: an unchecked cycle never reports an error.
  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_q |=> err_n);

endmodule

// File: rtl/cmd_regbuf.sv
module cmd_regbuf
  import cmd_regbuf_pkg::*;
#(
  parameter int unsigned DATA_W    = 28,
  parameter int unsigned CS_W      = 2,
  parameter int unsigned CKE_W     = 2,
  parameter int unsigned ODT_W     = 2,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_en,
  input  logic [DATA_W-1:0] d_in,
  input  logic [CS_W-1:0]   cs_n_in,
  input  logic [CKE_W-1:0]  cke_in,
  input  logic [ODT_W-1:0]  odt_in,
  input  logic              par_in,
  output logic [DATA_W-1:0] q_out,
  output logic [CS_W-1:0]   cs_n_out,
  output logic [CKE_W-1:0]  cke_out,
  output logic [ODT_W-1:0]  odt_out,
  output logic              err_n
);

  localparam int unsigned SIDE_W = CS_W + CKE_W + ODT_W;

  logic              rst_n_int;
  load_kind_e        kind;
  logic              load;
  logic              load_q;
  logic [SIDE_W-1:0] side_in, side_out;

  cmd_regbuf_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  cmd_regbuf_gate #(.CS_W(CS_W)) u_gate (
    .gate_en (gate_en),
    .cs_n    (cs_n_in),
    .kind    (kind)
  );

  assign load    = (kind != LOAD_BLOCKED);
  assign side_in = {odt_in, cke_in, cs_n_in};

  cmd_regbuf_pipe #(.DATA_W(DATA_W), .SIDE_W(SIDE_W)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (load),
    .d_in     (d_in),
    .side_in  (side_in),
    .q_out    (q_out),
    .side_out (side_out),
    .load_q   (load_q)
  );

  assign cs_n_out = side_out[CS_W-1:0];
  assign cke_out  = side_out[CS_W +: CKE_W];
  assign odt_out  = side_out[CS_W+CKE_W +: ODT_W];

  cmd_regbuf_parity #(.DATA_W(DATA_W)) u_par (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .load_q (load_q),
    .q      (q_out),
    .par_in (par_in),
    .err_n  (err_n)
  );

  // R2: in gated mode an active chip select must enable the load.
  assert_select_R2: assert property (@(posedge clk) disable iff (!rst_n_int)
    (gate_en && !(&cs_n_in)) |-> load);

  // R1: in free mode the load is never blocked.
  assert_free_R1: assert property (@(posedge clk) disable iff (!rst_n_int)
    !gate_en |-> (kind == LOAD_FREE));

endmodule

// File: tb/cmd_regbuf_bench.sv
`timescale 1ns/1ps
module cmd_regbuf_bench;

  localparam int DW = 28;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          gate_en;
  logic [DW-1:0] d_in;
  logic [1:0]    cs_n_in, cke_in, odt_in;
  logic          par_in;
  logic [DW-1:0] q_out;
  logic [1:0]    cs_n_out, cke_out, odt_out;
  logic          err_n;

  int total = 0;
  int bad   = 0;

  // Bench-side expectation state, built from the requirements.
  logic [DW-1:0] exp_q;
  logic [5:0]    exp_side;
  logic          exp_loadq;
  logic          exp_err;
  bit            fresh;

  always #2 clk = ~clk;

  cmd_regbuf u_cmd_regbuf (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .d_in(d_in),
    .cs_n_in(cs_n_in), .cke_in(cke_in), .odt_in(odt_in), .par_in(par_in),
    .q_out(q_out), .cs_n_out(cs_n_out), .cke_out(cke_out), .odt_out(odt_out),
    .err_n(err_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    exp_q = '0; exp_side = '0; exp_loadq = 1'b0; exp_err = 1'b1; fresh = 1'b1;
  endtask

  task automatic check_reset_vals(input string tag);
    chk(q_out == '0, tag, 32'(q_out), 32'h0);
    chk({odt_out, cke_out, cs_n_out} == 6'h0, tag,
        32'({odt_out, cke_out, cs_n_out}), 32'h0);
    chk(err_n == 1'b1, tag, 32'(err_n), 32'h1);
  endtask

  // One clock: drive at the falling edge, sample at the next falling edge.
  task automatic cycle(input logic g, input logic [DW-1:0] d, input logic [1:0] cs,
                       input logic [1:0] cke, input logic [1:0] odt, input logic p);
    logic  ld, new_err;
    string qtag, etag;
    gate_en = g; d_in = d; cs_n_in = cs; cke_in = cke; odt_in = odt; par_in = p;
    @(posedge clk);
    new_err = exp_loadq ? ~((^exp_q) ^ p) : 1'b1;
    etag    = exp_loadq ? "R5" : (fresh ? "R8" : "R6");
    ld      = !g || !(&cs);
    qtag    = !g ? "R1" : (ld ? "R2" : "R3");
    exp_err = new_err;
    exp_loadq = ld;
    if (ld) exp_q = d;
    exp_side = {odt, cke, cs};
    @(negedge clk);
    chk(q_out == exp_q, qtag, 32'(q_out), 32'(exp_q));
    chk({odt_out, cke_out, cs_n_out} == exp_side, "R4",
        32'({odt_out, cke_out, cs_n_out}), 32'(exp_side));
    chk(err_n == exp_err, etag, 32'(err_n), 32'(exp_err));
    fresh = 1'b0;
  endtask

  // R7, R9: async clear, then two held edges before the first load.
  task automatic t_reset(input logic [DW-1:0] pat);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_vals("R7");
    repeat (2) @(negedge clk);
    gate_en = 1'b0; d_in = pat; cs_n_in = 2'b01; cke_in = 2'b11; odt_in = 2'b10;
    par_in = 1'b1;
    rst_n = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check_reset_vals("R9");
    end
    model_reset();
    cycle(1'b0, pat, 2'b01, 2'b11, 2'b10, 1'b1);
    chk(q_out == pat, "R9", 32'(q_out), 32'(pat));
  endtask

  task automatic t_ungated();
    logic [DW-1:0] prev;
    prev = 28'h0000001;
    cycle(1'b0, prev, 2'b11, 2'b00, 2'b00, 1'b0);
    for (int i = 0; i < 6; i++) begin
      logic [DW-1:0] d;
      d = DW'(32'h9E3779B9 * (i + 3));
      cycle(1'b0, d, 2'(i), 2'(i + 1), 2'(i + 2), ^prev);
      prev = d;
    end
  endtask

  task automatic t_gated_cs();
    logic [DW-1:0] prev;
    prev = exp_q;
    for (int i = 0; i < 4; i++) begin
      logic [DW-1:0] d;
      d = DW'(32'h0ACE1234 + 32'(i) * 32'h01111111);
      cycle(1'b1, d, 2'(i), 2'(3 - i), 2'(i), ^prev);
      if (i != 3) prev = d;
    end
    // Both selects high again with a fresh pattern: still held.
    cycle(1'b1, 28'hFFFFFFF, 2'b11, 2'b01, 2'b01, 1'b0);
    cycle(1'b1, 28'h5555555, 2'b10, 2'b10, 2'b11, 1'b0);
  endtask

  task automatic t_parity();
    logic [DW-1:0] d1, d2;
    d1 = 28'h1234567;
    d2 = 28'h0F0F0F1;
    cycle(1'b0, d1, 2'b00, 2'b11, 2'b00, 1'b0);
    cycle(1'b0, d2, 2'b00, 2'b11, 2'b00, ~(^d1));
    cycle(1'b0, d1, 2'b00, 2'b11, 2'b00, ^d2);
    cycle(1'b0, d2, 2'b00, 2'b11, 2'b00, ~(^d1));
    cycle(1'b0, d2, 2'b00, 2'b11, 2'b00, ~(^d2));
    chk(err_n == 1'b0, "R5", 32'(err_n), 32'h0);
  endtask

  task automatic t_gap();
    logic [DW-1:0] d;
    d = 28'hABCDEF0;
    cycle(1'b1, d, 2'b01, 2'b00, 2'b00, 1'b0);
    cycle(1'b1, 28'h0000000, 2'b11, 2'b00, 2'b00, ^d);
    cycle(1'b1, 28'h0000000, 2'b11, 2'b00, 2'b00, ~(^d));
    chk(err_n == 1'b1, "R6", 32'(err_n), 32'h1);
    cycle(1'b1, 28'h7777777, 2'b11, 2'b00, 2'b00, 1'b1);
  endtask

  // R8: a mid-run reset, then a bad parity right after the first load.
  task automatic t_reset_mid();
    logic [DW-1:0] d;
    t_reset(28'h8000001);
    d = 28'h0000003;
    cycle(1'b0, d, 2'b00, 2'b00, 2'b00, 1'b1);
    cycle(1'b0, d, 2'b00, 2'b00, 2'b00, ~(^d));
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", total, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; gate_en = 1'b0; d_in = '0; cs_n_in = 2'b11;
    cke_in = '0; odt_in = '0; par_in = 1'b0;
    model_reset();
    t_reset(28'hC0FFEE1);
    t_ungated();
    t_gated_cs();
    t_parity();
    t_gap();
    t_reset_mid();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule